// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Per-Operation Flag Masks

This unit is the datapath core of a small 8-bit RISC processor. Each clock it takes two operands, a carry input, a 5-bit operation code and the current status byte. One clock edge later it presents the 8-bit result and the updated status byte. The surrounding core writes the result back to its register file and keeps the status byte.

Each operation has its own set of flags that it may write. Every status bit outside that set passes through unchanged from `flags_i`. This lets the core chain multi-byte arithmetic and compares, and lets it keep a carry across increment loops. A flag set/clear operation writes one status bit picked by the low three bits of operand B.

The status byte has a fixed layout, from bit 7 down to bit 0: I (7), T (6), H (5), S (4), V (3), N (2), Z (1), C (0). In the requirements below, H is the carry or borrow out of bit 3, N is result bit 7 and Z means the result is zero.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `result_o` and `flags_o` are 0. Out of reset, the inputs sampled at one rising edge appear on the outputs right after that edge and hold for one cycle. The status byte layout is I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: ADD (op 0x00) produces A+B and ADC (op 0x01) produces A+B+cin, both modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, and N, Z and S are written too.
- R3: SUB (op 0x02) produces A-B and SBC (op 0x03) produces A-B-cin. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow. CP (op 0x04) sets the flags the way SUB does but returns A as the result.
- R4: CPC (op 0x05) sets C, H, N, V and S as for A-B-cin and returns A. If the difference is zero, Z keeps its incoming value; otherwise Z is cleared.
- R5: AND (op 0x06), OR (op 0x07) and XOR (op 0x08) write Z, N and S, and force V to 0. C, H, I and T keep their incoming values.
- R6: INC (op 0x0B) returns A+1 and DEC (op 0x0C) returns A-1, modulo 256. Only Z, N, V and S change. V is 1 exactly when A is 0x7F for INC, or 0x80 for DEC.
- R7: COM (op 0x09) returns 0xFF-A with C=1 and V=0, and leaves H unchanged. NEG (op 0x0A) returns 0x00-A with C=(A!=0), H=(A[3:0]!=0) and V=(A==0x80).
- R8: LSL (0x0D) returns {A[6:0],0}. LSR (0x0E) returns {0,A[7:1]}. ROL (0x0F) returns {A[6:0],cin}. ROR (0x10) returns {cin,A[7:1]}. ASR (0x11) returns {A[7],A[7:1]}. C receives the bit shifted out, V equals the new N XOR the new C, and H is unchanged.
- R9: SWAP (op 0x12) returns {A[3:0],A[7:4]} and leaves every status bit unchanged.
- R10: Every operation that writes N or V also writes S as the new N XOR the new V. No operation other than flag set/clear changes I or T.
- R11: FSET (op 0x13) and FCLR (op 0x14) write 1 or 0 into the status bit whose index is B[2:0]. All other status bits are unchanged, and the result is A.
- R12: Op codes 0x15 to 0x1F return A and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Operand A (destination operand) |
| b_i | input | 8 | Operand B; B[2:0] selects the bit for FSET/FCLR |
| carry_i | input | 1 | Carry input for ADC, SBC, CPC, ROL, ROR |
| flags_i | input | 8 | Current status byte |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered updated status byte |

## Verification
The assertions check several properties on every cycle:
- SWAP never changes the status byte.
- Compares return operand A.
- Increment and decrement keep C and H.
- Complement forces C high and V low.
- S always equals N XOR V after an operation that writes them.
- Shifts satisfy V = N XOR C.
- I and T move only under flag set/clear, and a set/clear changes at most one bit.
- Unused op codes are inert.

The values of sums, borrows, half-carries and overflow thresholds cannot be stated as simple temporal properties. Neither can the Z chaining of CPC across its incoming Z. Only the bench's sweeps, compared against arithmetic computed independently, can show these.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    localparam int STAT_W = 8;
    localparam int OP_W   = 5;

    // status bit positions (the core decodes them at these indices)
    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_S = 4;
    localparam int FLAG_H = 5;
    localparam int FLAG_T = 6;
    localparam int FLAG_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'h00,
        OP_ADC  = 5'h01,
        OP_SUB  = 5'h02,
        OP_SBC  = 5'h03,
        OP_CP   = 5'h04,
        OP_CPC  = 5'h05,
        OP_AND  = 5'h06,
        OP_OR   = 5'h07,
        OP_XOR  = 5'h08,
        OP_COM  = 5'h09,
        OP_NEG  = 5'h0A,
        OP_INC  = 5'h0B,
        OP_DEC  = 5'h0C,
        OP_LSL  = 5'h0D,
        OP_LSR  = 5'h0E,
        OP_ROL  = 5'h0F,
        OP_ROR  = 5'h10,
        OP_ASR  = 5'h11,
        OP_SWAP = 5'h12,
        OP_FSET = 5'h13,
        OP_FCLR = 5'h14
    } opcode_e;

    typedef enum logic [2:0] {
        CLS_ARITH,
        CLS_BITWISE,
        CLS_SHIFT,
        CLS_FLAG,
        CLS_NONE
    } op_class_e;

    function automatic op_class_e op_class(input opcode_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
            OP_NEG, OP_INC, OP_DEC:                     return CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_SWAP:     return CLS_BITWISE;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:     return CLS_SHIFT;
            OP_FSET, OP_FCLR:                           return CLS_FLAG;
            default:                                    return CLS_NONE;
        endcase
    endfunction

    // set of status bits an operation is allowed to write
    function automatic logic [STAT_W-1:0] flag_mask(input opcode_e op);
        logic [STAT_W-1:0] m;
        m = '0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                m[FLAG_C] = 1'b1; m[FLAG_Z] = 1'b1; m[FLAG_N] = 1'b1;
                m[FLAG_V] = 1'b1; m[FLAG_S] = 1'b1; m[FLAG_H] = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                m[FLAG_Z] = 1'b1; m[FLAG_N] = 1'b1;
                m[FLAG_V] = 1'b1; m[FLAG_S] = 1'b1;
            end
            OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                m[FLAG_C] = 1'b1; m[FLAG_Z] = 1'b1; m[FLAG_N] = 1'b1;
                m[FLAG_V] = 1'b1; m[FLAG_S] = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              half_o,
    output logic              ovf_o
);
    localparam int MSB  = DATA_W - 1;
    localparam int HALF = DATA_W / 2;

    logic [DATA_W:0] wide_d;
    logic [HALF:0]   low_d;

    always_comb begin
        if (sub_i) begin
            wide_d = {1'b0, opa_i} - {1'b0, opb_i} - {{DATA_W{1'b0}}, cin_i};
            low_d  = {1'b0, opa_i[HALF-1:0]} - {1'b0, opb_i[HALF-1:0]}
                     - {{HALF{1'b0}}, cin_i};
            ovf_o  = (opa_i[MSB] ^ opb_i[MSB]) & (opa_i[MSB] ^ wide_d[MSB]);
        end else begin
            wide_d = {1'b0, opa_i} + {1'b0, opb_i} + {{DATA_W{1'b0}}, cin_i};
            low_d  = {1'b0, opa_i[HALF-1:0]} + {1'b0, opb_i[HALF-1:0]}
                     + {{HALF{1'b0}}, cin_i};
            ovf_o  = ~(opa_i[MSB] ^ opb_i[MSB]) & (opa_i[MSB] ^ wide_d[MSB]);
        end
        sum_o   = wide_d[MSB:0];
        carry_o = wide_d[DATA_W];
        half_o  = low_d[HALF];
    end

endmodule

// File: rtl/alu8_bitops.sv
`timescale 1ns/1ps
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    localparam int MSB  = DATA_W - 1;
    localparam int HALF = DATA_W / 2;

    always_comb begin
        res_o   = a_i;
        carry_o = 1'b0;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM: begin
                res_o   = ~a_i;
                carry_o = 1'b1;
            end
            OP_LSL: begin
                res_o   = {a_i[MSB-1:0], 1'b0};
                carry_o = a_i[MSB];
            end
            OP_LSR: begin
                res_o   = {1'b0, a_i[MSB:1]};
                carry_o = a_i[0];
            end
            OP_ROL: begin
                res_o   = {a_i[MSB-1:0], cin_i};
                carry_o = a_i[MSB];
            end
            OP_ROR: begin
                res_o   = {cin_i, a_i[MSB:1]};
                carry_o = a_i[0];
            end
            OP_ASR: begin
                res_o   = {a_i[MSB], a_i[MSB:1]};
                carry_o = a_i[0];
            end
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[MSB:HALF]};
            default: begin
                res_o   = a_i;
                carry_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_flagmux.sv
`timescale 1ns/1ps
module alu8_flagmux
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              as_carry_i,
    input  logic              as_half_i,
    input  logic              as_ovf_i,
    input  logic              bo_carry_i,
    input  logic [2:0]        sel_i,
    input  logic [STAT_W-1:0] flags_i,
    output logic [STAT_W-1:0] flags_o
);
    localparam int MSB = DATA_W - 1;

    op_class_e         cls;
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] cand;
    logic              n_new, z_new, c_new, v_new;

    always_comb begin
        cls   = op_class(op_i);
        mask  = flag_mask(op_i);
        n_new = res_i[MSB];
        z_new = ~|res_i;
        if (op_i == OP_CPC) begin
            z_new = z_new & flags_i[FLAG_Z];   // chain multi-byte compare
        end
        c_new = (cls == CLS_ARITH) ? as_carry_i : bo_carry_i;
        case (cls)
            CLS_ARITH: v_new = as_ovf_i;
            CLS_SHIFT: v_new = n_new ^ c_new;
            default:   v_new = 1'b0;
        endcase

        cand         = '0;
        cand[FLAG_C] = c_new;
        cand[FLAG_Z] = z_new;
        cand[FLAG_N] = n_new;
        cand[FLAG_V] = v_new;
        cand[FLAG_S] = n_new ^ v_new;
        cand[FLAG_H] = as_half_i;

        flags_o = (flags_i & ~mask) | (cand & mask);
        if (op_i == OP_FSET) begin
            flags_o          = flags_i;
            flags_o[sel_i]   = 1'b1;
        end else if (op_i == OP_FCLR) begin
            flags_o          = flags_i;
            flags_o[sel_i]   = 1'b0;
        end
    end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_i,
    input  logic [STAT_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [STAT_W-1:0] flags_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [STAT_W-1:0] stat;
    } stage_t;

    stage_t            st_d, st_q;
    opcode_e           op;
    op_class_e         cls;

    logic [DATA_W-1:0] as_a, as_b, as_sum;
    logic              as_cin, as_sub, as_c, as_h, as_v;
    logic [DATA_W-1:0] bo_res;
    logic              bo_c;
    logic [DATA_W-1:0] res_sel;
    logic [STAT_W-1:0] stat_next;

    assign op  = opcode_e'(op_i);
    assign cls = op_class(op);

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_a   = a_i;
        as_b   = b_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:          as_cin = carry_i;
            OP_SUB, OP_CP:   as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = carry_i;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = a_i;
                as_sub = 1'b1;
            end
            OP_INC:          as_b = DATA_W'(1);
            OP_DEC: begin
                as_b   = DATA_W'(1);
                as_sub = 1'b1;
            end
            default: begin
                as_a   = a_i;
                as_b   = b_i;
            end
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opa_i   (as_a),
        .opb_i   (as_b),
        .cin_i   (as_cin),
        .sub_i   (as_sub),
        .sum_o   (as_sum),
        .carry_o (as_c),
        .half_o  (as_h),
        .ovf_o   (as_v)
    );

    alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op_i    (op),
        .a_i     (a_i),
        .b_i     (b_i),
        .cin_i   (carry_i),
        .res_o   (bo_res),
        .carry_o (bo_c)
    );

    always_comb begin
        case (cls)
            CLS_ARITH:   res_sel = (op == OP_CP || op == OP_CPC) ? a_i : as_sum;
            CLS_BITWISE,
            CLS_SHIFT:   res_sel = bo_res;
            default:     res_sel = a_i;
        endcase
    end

    alu8_flagmux #(.DATA_W(DATA_W)) u_flags (
        .op_i       (op),
        .res_i      (cls == CLS_ARITH ? as_sum : res_sel),
        .as_carry_i (as_c),
        .as_half_i  (as_h),
        .as_ovf_i   (as_v),
        .bo_carry_i (bo_c),
        .sel_i      (b_i[2:0]),
        .flags_i    (flags_i),
        .flags_o    (stat_next)
    );

    always_comb begin
        st_d.res  = res_sel;
        st_d.stat = stat_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign flags_o  = st_q.stat;

    // ---------------- assertions ----------------
    logic [STAT_W-1:0] cur_mask;
    assign cur_mask = flag_mask(op);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && flags_o == '0)); // R1

    AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CP || op == OP_CPC) |=> result_o == $past(a_i)); // R3

    AST_LOGIC_CLR_V: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_AND || op == OP_OR || op == OP_XOR) |=>
        (!flags_o[FLAG_V] && flags_o[FLAG_C] == $past(flags_i[FLAG_C])
         && flags_o[FLAG_H] == $past(flags_i[FLAG_H]))); // R5

    AST_INCDEC_KEEP_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC || op == OP_DEC) |=>
        (flags_o[FLAG_C] == $past(flags_i[FLAG_C])
         && flags_o[FLAG_H] == $past(flags_i[FLAG_H]))); // R6

    AST_COM_FORCE_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_COM) |=> (flags_o[FLAG_C] && !flags_o[FLAG_V])); // R7

    AST_SHIFT_V_NXC: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_SHIFT) |=>
        flags_o[FLAG_V] == (flags_o[FLAG_N] ^ flags_o[FLAG_C])); // R8

    AST_SWAP_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SWAP) |=> flags_o == $past(flags_i)); // R9

    AST_SIGN_IS_NXV: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mask[FLAG_N] |=>
        flags_o[FLAG_S] == (flags_o[FLAG_N] ^ flags_o[FLAG_V])); // R10

    AST_IT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cls != CLS_FLAG) |=> flags_o[FLAG_I:FLAG_T] == $past(flags_i[FLAG_I:FLAG_T])); // R10

    AST_FLAG_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_FLAG) |=>
        ($countones(flags_o ^ $past(flags_i)) <= 1 && result_o == $past(a_i))); // R11

    AST_IDLE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_NONE) |=>
        (result_o == $past(a_i) && flags_o == $past(flags_i))); // R12

endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       carry_i = 1'b0;
    logic [7:0] flags_i = '0;
    logic [7:0] result_o;
    logic [7:0] flags_o;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .carry_i  (carry_i),
        .flags_i  (flags_i),
        .result_o (result_o),
        .flags_o  (flags_o)
    );

    function automatic string tag_of(input int op);
        if (op <= 1)  return "R2";
        if (op <= 4)  return "R3";
        if (op == 5)  return "R4";
        if (op <= 8)  return "R5";
        if (op <= 10) return "R7";
        if (op <= 12) return "R6";
        if (op <= 17) return "R8";
        if (op == 18) return "R9";
        if (op <= 20) return "R11";
        return "R12";
    endfunction

    // reference computed arithmetically from the requirements
    task automatic model(input int op, input int a, input int b, input int ci,
                         input int fin, output int r, output int f);
        int t, c, h, v, n, z, mask, cand;
        c = 0; h = 0; v = 0; mask = 0; r = a; f = fin;
        z = -1;
        case (op)
            0, 1: begin
                t = a + b + ((op == 1) ? ci : 0);
                r = t & 255; c = (t > 255);
                h = (((a & 15) + (b & 15) + ((op == 1) ? ci : 0)) > 15);
                v = (((a ^ r) & (b ^ r) & 128) != 0);
                mask = 8'h3F;
            end
            2, 3, 4, 5: begin
                int cc;
                cc = (op == 3 || op == 5) ? ci : 0;
                t = a - b - cc;
                r = t & 255; c = (t < 0);
                h = (((a & 15) - (b & 15) - cc) < 0);
                v = (((a ^ b) & (a ^ r) & 128) != 0);
                mask = 8'h3F;
                if (op == 5) z = (r == 0) ? ((fin >> 1) & 1) : 0;
            end
            6: begin r = a & b; mask = 8'h1E; end
            7: begin r = a | b; mask = 8'h1E; end
            8: begin r = a ^ b; mask = 8'h1E; end
            9: begin r = 255 - a; c = 1; mask = 8'h1F; end
            10: begin
                r = (256 - a) & 255; c = (a != 0); h = ((a & 15) != 0);
                v = (a == 128); mask = 8'h3F;
            end
            11: begin r = (a + 1) & 255; v = (a == 127); mask = 8'h1E; end
            12: begin r = (a + 255) & 255; v = (a == 128); mask = 8'h1E; end
            13: begin r = (a << 1) & 255; c = a >> 7; end
            14: begin r = a >> 1; c = a & 1; end
            15: begin r = ((a << 1) | ci) & 255; c = a >> 7; end
            16: begin r = (a >> 1) | (ci << 7); c = a & 1; end
            17: begin r = (a >> 1) | (a & 128); c = a & 1; end
            18: begin r = ((a & 15) << 4) | (a >> 4); end
            default: ;
        endcase
        if (op == 5) r = r; // flags use the difference, result set below
        n = (r >> 7) & 1;
        if (z < 0) z = (r == 0);
        if (op >= 13 && op <= 17) begin v = n ^ c; mask = 8'h1F; end
        cand = c | (z << 1) | (n << 2) | (v << 3) | ((n ^ v) << 4) | (h << 5);
        f = (fin & ~mask & 255) | (cand & mask);
        if (op == 4 || op == 5) r = a;
        if (op == 19) f = fin | (1 << (b & 7));
        if (op == 20) f = fin & ~(1 << (b & 7)) & 255;
    endtask

    task automatic run_vec(input int op, input int a, input int b, input int ci,
                           input int fin, input string tag);
        int er, ef;
        @(negedge clk);
        op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0];
        carry_i = ci[0]; flags_i = fin[7:0];
        @(posedge clk);
        #1;
        model(op, a, b, ci, fin, er, ef);
        tests++;
        if (result_o !== er[7:0] || flags_o !== ef[7:0]) begin
            failed++;
            $display("FAIL %s op=%0h a=%0h b=%0h cin=%0d fin=%0h: got res=%0h flags=%0h, expected res=%0h flags=%0h",
                     tag, op, a, b, ci, fin, result_o, flags_o, er[7:0], ef[7:0]);
        end
    endtask

    task automatic check_bits(input logic [7:0] got, input logic [7:0] exp,
                              input string tag);
        tests++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %0h, expected %0h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_bits(result_o, 8'h00, "R1 reset result");
        check_bits(flags_o, 8'h00, "R1 reset flags");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: latency of one edge
        run_vec(0, 8'h12, 8'h34, 0, 8'h00, "R1");
        check_bits(result_o, 8'h46, "R1 latency result");

        // R4: CPC Z chaining, equal operands
        run_vec(5, 8'h10, 8'h10, 0, 8'h02, "R4");
        check_bits(flags_o & 8'h02, 8'h02, "R4 zero keeps Z=1");
        run_vec(5, 8'h10, 8'h10, 0, 8'h00, "R4");
        check_bits(flags_o & 8'h02, 8'h00, "R4 zero keeps Z=0");
        run_vec(5, 8'h11, 8'h10, 0, 8'h02, "R4");
        check_bits(flags_o & 8'h02, 8'h00, "R4 nonzero clears Z");

        // R10: I/T kept, S = N^V on overflow to 0x80
        run_vec(0, 8'h7F, 8'h01, 0, 8'hC0, "R10");
        check_bits(flags_o & 8'hDC, 8'hCC, "R10 I,T kept, V=1 N=1 S=0");

        // R6 boundaries
        run_vec(11, 8'h7F, 0, 0, 8'h21, "R6");
        check_bits(flags_o, 8'h2D, "R6 INC 0x7F flags");
        run_vec(12, 8'h80, 0, 0, 8'h00, "R6");
        check_bits(flags_o, 8'h18, "R6 DEC 0x80 flags");

        // R11: every bit index, set then clear
        for (int s = 0; s < 8; s++) begin
            run_vec(19, 8'h5A, s, 0, 8'h00, "R11");
            run_vec(20, 8'hA5, s, 0, 8'hFF, "R11");
        end

        // sweep all op codes (R2..R12)
        for (int op = 0; op < 32; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 4; k++) begin
                    run_vec(op, a, (a * 37 + k * 91 + op * 13) & 255, k & 1,
                            (a * 29 + k * 71 + op * 5) & 255, tag_of(op));
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule